// File: doc/BRIEF.md
# Sampled Grid Phase Tracker with Wrapped Error

This block locks a square synchronization pulse to a single-phase mains voltage. On each sample strobe it multiplies the signed grid sample by a ±1 square wave taken from its own phase accumulator. It then smooths the product with a first-order low-pass filter. A vectoring-mode CORDIC turns the smoothed value and a fixed reference term into a four-quadrant angle. That angle is the phase error, wrapped into the interval from minus pi up to (but not including) pi.

The wrapped error drives a proportional-integral filter. The filter sets the step of a 16-bit phase accumulator, in which full scale is pi. Because the error is bounded by the arctangent before it reaches the filter, a sudden 180-degree jump of the grid phase cannot push the loop into a runaway frequency excursion. The sync pulse is the accumulator's positive half-cycle.

A lock flag reports a long run of small errors. The gains and the lock threshold are inputs, so a controller can retune the loop without a reset.

Top module: `gsync_pll`

## Requirements
- R1: A synchronous reset `rst` clears the phase accumulator, the integrator, the filter state, the wrapped error and the lock count. After reset, `phase_out`=0, `err_out`=0, `locked`=0 and `sync_out`=1.
- R2: For each strobe, the accumulator advances once, 15 clock edges after the strobe edge. The step is `W0 + ((kp*e + I) >>> 8)`, taken modulo 2^16. Here `e` is the signed `err_out` used for that update, `I` is the integrator after its update, `kp` is unsigned and `W0` defaults to 492 (60 Hz at 8 kHz).
- R3: The phase is a 16-bit two's-complement value in which 32768 stands for pi. A phase that passes pi loses 2·pi, which means it wraps modulo 65536.
- R4: `sync_out` is 1 while `phase_out` lies in [0, pi), which is when bit 15 is 0. It is 0 otherwise.
- R5: On each strobe, the product `p` is `smp_in` when `sync_out` is 1 at the strobe and `-smp_in` otherwise. The filter is updated as `y += (p - y) >>> 3`. `err_out` equals atan2(y, 4096) scaled so that pi is 32768, within ±24 LSB, in the range [-32768, 32767].
- R6: With `ki`=0, the step is `W0 + ((kp*e) >>> 8)`.
- R7: The integrator is updated as `I += ki*e` (with `ki` unsigned) and saturates at ±(2^23−1).
- R8: `locked` goes to 1 at the update that completes 256 consecutive updates with |e| < `lock_thr` (unsigned compare). Any update with |e| ≥ `lock_thr` clears the run and `locked` at once.
- R9: Without a strobe, no state changes: `phase_out` and `err_out` hold. Strobes must be at least 16 clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | One-cycle sample strobe |
| smp_in | input | 16 | Signed grid sample |
| kp | input | 8 | Proportional gain, unsigned |
| ki | input | 8 | Integral gain, unsigned |
| lock_thr | input | 16 | Lock error threshold, unsigned |
| sync_out | output | 1 | Square synchronization pulse |
| locked | output | 1 | Lock indication |
| err_out | output | 16 | Wrapped phase error, pi = 32768 |
| phase_out | output | 16 | Accumulator phase, pi = 32768 |

## Verification
A corrupted accumulator or step word shows up in `phase_out` and `sync_out` at the first strobe after the fault, 15 edges later. A bad filter state or a bad CORDIC iteration shows in `err_out` for that same sample, and from then on it skews every following phase step. A fault in the integrator or in its saturation stays hidden while `ki` is 0. Once `ki` is nonzero, it appears in the phase step within one sample. A miscount in the lock logic moves the rise of `locked` away from the 256th in-band update.

// File: rtl/gsync_pkg.sv
package gsync_pkg;
    // phase word width; full scale equals pi
    localparam int PH_W = 16;

    // arctangent of 2^-i in phase units (pi = 32768)
    function automatic logic [PH_W-1:0] atan_step(input int i);
        case (i)
            0:       atan_step = 16'd8192;
            1:       atan_step = 16'd4836;
            2:       atan_step = 16'd2555;
            3:       atan_step = 16'd1297;
            4:       atan_step = 16'd651;
            5:       atan_step = 16'd326;
            6:       atan_step = 16'd163;
            7:       atan_step = 16'd81;
            8:       atan_step = 16'd41;
            9:       atan_step = 16'd20;
            10:      atan_step = 16'd10;
            11:      atan_step = 16'd5;
            12:      atan_step = 16'd3;
            13:      atan_step = 16'd1;
            default: atan_step = 16'd0;
        endcase
    endfunction
endpackage

// File: rtl/gsync_pd_lpf.sv
module gsync_pd_lpf #(
    parameter int IN_W   = 16,
    parameter int LPF_SH = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic signed [IN_W-1:0] sample,
    input  logic                   sq_pos,
    output logic signed [IN_W+1:0] filt
);
    localparam int F_W = IN_W + 2;

    typedef struct packed {
        logic [F_W-1:0] y;
    } lpf_st_t;

    lpf_st_t f_d, f_q;
    logic signed [F_W-1:0] prod;
    logic signed [F_W-1:0] diff;

    always_comb begin
        f_d  = f_q;
        prod = sq_pos ? F_W'(sample) : -F_W'(sample);
        diff = prod - $signed(f_q.y);
        if (en) begin
            f_d.y = $signed(f_q.y) + (diff >>> LPF_SH);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    assign filt = $signed(f_q.y);

    assert_lpf_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(f_q.y));
endmodule

// File: rtl/gsync_cordic.sv
module gsync_cordic #(
    parameter int IN_W = 18,
    parameter int ITER = 12
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic signed [IN_W-1:0]          xin,
    input  logic signed [IN_W-1:0]          yin,
    output logic                            busy,
    output logic                            done,
    output logic [gsync_pkg::PH_W-1:0]      ang
);
    localparam int PH_W  = gsync_pkg::PH_W;
    localparam int W     = IN_W + 2;
    localparam int CNT_W = $clog2(ITER);

    typedef struct packed {
        logic [W-1:0]     x;
        logic [W-1:0]     y;
        logic [PH_W-1:0]  z;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
        logic [PH_W-1:0]  ang;
    } cor_st_t;

    cor_st_t c_d, c_q;
    logic signed [W-1:0] xs, ys, xw, yw;
    logic [PH_W-1:0]     step;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        xw       = W'(xin);
        yw       = W'(yin);
        xs       = $signed(c_q.x) >>> c_q.cnt;
        ys       = $signed(c_q.y) >>> c_q.cnt;
        step     = gsync_pkg::atan_step(int'(c_q.cnt));
        if (start) begin
            // left half plane: rotate by pi first
            if (xin < 0) begin
                c_d.x = -xw;
                c_d.y = -yw;
                c_d.z = {1'b1, {(PH_W-1){1'b0}}};
            end else begin
                c_d.x = xw;
                c_d.y = yw;
                c_d.z = '0;
            end
            c_d.cnt  = '0;
            c_d.busy = 1'b1;
        end else if (c_q.busy) begin
            if (!c_q.y[W-1]) begin
                c_d.x = $signed(c_q.x) + ys;
                c_d.y = $signed(c_q.y) - xs;
                c_d.z = c_q.z + step;
            end else begin
                c_d.x = $signed(c_q.x) - ys;
                c_d.y = $signed(c_q.y) + xs;
                c_d.z = c_q.z - step;
            end
            if (c_q.cnt == CNT_W'(ITER - 1)) begin
                c_d.busy = 1'b0;
                c_d.done = 1'b1;
                c_d.ang  = c_d.z;
            end else begin
                c_d.cnt = c_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign busy = c_q.busy;
    assign done = c_q.done;
    assign ang  = c_q.ang;

    assert_iter_range_R5: assert property (@(posedge clk) disable iff (rst)
        c_q.busy |-> (int'(c_q.cnt) < ITER));
    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
        c_q.done |-> (!c_q.busy && $past(c_q.busy)));
    assert_angle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !c_d.done |=> $stable(c_q.ang));
endmodule

// File: rtl/gsync_loop.sv
module gsync_loop #(
    parameter int G_W     = 8,
    parameter int INT_W   = 24,
    parameter int FILT_SH = 8,
    parameter int W0      = 492,
    parameter int LOCK_N  = 256
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               upd,
    input  logic signed [gsync_pkg::PH_W-1:0]  err,
    input  logic [G_W-1:0]                     kp,
    input  logic [G_W-1:0]                     ki,
    input  logic [gsync_pkg::PH_W-1:0]         lock_thr,
    output logic [gsync_pkg::PH_W-1:0]         phase,
    output logic                               locked
);
    localparam int PH_W  = gsync_pkg::PH_W;
    localparam int P_W   = PH_W + G_W + 1;
    localparam int S_W   = INT_W + 2;
    localparam int LC_W  = $clog2(LOCK_N + 1);
    localparam logic signed [S_W-1:0]  IMAX = S_W'((2 ** (INT_W - 1)) - 1);
    localparam logic [PH_W-1:0]        W0_V = PH_W'(W0);
    localparam logic [LC_W-1:0]        LMAX = LC_W'(LOCK_N);

    typedef struct packed {
        logic [INT_W-1:0] integ;
        logic [PH_W-1:0]  phase;
        logic [LC_W-1:0]  cnt;
        logic             locked;
    } loop_st_t;

    loop_st_t l_d, l_q;
    logic signed [P_W-1:0]  prop, iterm;
    logic signed [S_W-1:0]  isum, inext, uf, ufs;
    logic signed [PH_W:0]   e_ext;
    logic [PH_W:0]          mag;
    logic                   in_band;

    always_comb begin
        l_d     = l_q;
        prop    = $signed({1'b0, kp}) * err;
        iterm   = $signed({1'b0, ki}) * err;
        isum    = S_W'($signed(l_q.integ)) + S_W'(iterm);
        if (isum > IMAX)       inext = IMAX;
        else if (isum < -IMAX) inext = -IMAX;
        else                   inext = isum;
        uf      = S_W'(prop) + inext;
        ufs     = uf >>> FILT_SH;
        e_ext   = {err[PH_W-1], err};
        mag     = e_ext[PH_W] ? unsigned'(-e_ext) : unsigned'(e_ext);
        in_band = mag < {1'b0, lock_thr};
        if (upd) begin
            l_d.integ = inext[INT_W-1:0];
            l_d.phase = l_q.phase + W0_V + ufs[PH_W-1:0];
            if (!in_band)           l_d.cnt = '0;
            else if (l_q.cnt != LMAX) l_d.cnt = l_q.cnt + 1'b1;
            l_d.locked = (l_d.cnt == LMAX);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) l_q <= '0;
        else     l_q <= l_d;
    end

    assign phase  = l_q.phase;
    assign locked = l_q.locked;

    assert_integ_sat_R7: assert property (@(posedge clk) disable iff (rst)
        (S_W'($signed(l_q.integ)) <= IMAX) && (S_W'($signed(l_q.integ)) >= -IMAX));
    assert_phase_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(l_q.phase));
    assert_lock_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(l_q.locked) |-> $past(upd));
    assert_lock_count_R8: assert property (@(posedge clk) disable iff (rst)
        l_q.locked |-> (l_q.cnt == LMAX));
endmodule

// File: rtl/gsync_pll.sv
module gsync_pll #(
    parameter int IN_W    = 16,
    parameter int LPF_SH  = 3,
    parameter int ITER    = 12,
    parameter int ATAN_X  = 4096,
    parameter int G_W     = 8,
    parameter int INT_W   = 24,
    parameter int FILT_SH = 8,
    parameter int W0      = 492,
    parameter int LOCK_N  = 256
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   smp_en,
    input  logic signed [IN_W-1:0] smp_in,
    input  logic [G_W-1:0]         kp,
    input  logic [G_W-1:0]         ki,
    input  logic [15:0]            lock_thr,
    output logic                   sync_out,
    output logic                   locked,
    output logic [15:0]            err_out,
    output logic [15:0]            phase_out
);
    localparam int PH_W = gsync_pkg::PH_W;
    localparam int F_W  = IN_W + 2;
    localparam logic signed [F_W-1:0] XREF = F_W'(ATAN_X);

    typedef struct packed {
        logic start;
    } top_st_t;

    top_st_t t_d, t_q;
    logic signed [F_W-1:0] filt;
    logic                  cor_busy, cor_done;
    logic [PH_W-1:0]       ang, phase;

    always_comb begin
        t_d       = t_q;
        t_d.start = smp_en;
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    gsync_pd_lpf #(.IN_W(IN_W), .LPF_SH(LPF_SH)) u_pd (
        .clk(clk), .rst(rst), .en(smp_en), .sample(smp_in),
        .sq_pos(!phase[PH_W-1]), .filt(filt)
    );

    gsync_cordic #(.IN_W(F_W), .ITER(ITER)) u_cor (
        .clk(clk), .rst(rst), .start(t_q.start), .xin(XREF), .yin(filt),
        .busy(cor_busy), .done(cor_done), .ang(ang)
    );

    gsync_loop #(.G_W(G_W), .INT_W(INT_W), .FILT_SH(FILT_SH), .W0(W0),
                 .LOCK_N(LOCK_N)) u_loop (
        .clk(clk), .rst(rst), .upd(cor_done), .err(ang), .kp(kp), .ki(ki),
        .lock_thr(lock_thr), .phase(phase), .locked(locked)
    );

    assign sync_out  = !phase[PH_W-1];
    assign err_out   = ang;
    assign phase_out = phase;

    assert_no_overrun_R9: assert property (@(posedge clk) disable iff (rst)
        smp_en |-> !(t_q.start || cor_busy || cor_done));
    assert_sync_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !cor_done |=> $stable(sync_out));
endmodule

// File: tb/sim_gsync_pll.sv
module sim_gsync_pll;
    localparam int  CLK_P = 10;
    localparam real PI_R  = 3.14159265358979;
    localparam longint IMAX = 64'd8388607;

    logic clk = 0, rst = 1, smp_en = 0;
    logic signed [15:0] smp_in = '0;
    logic [7:0]  kp = 0, ki = 0;
    logic [15:0] lock_thr = 0;
    logic sync_out, locked;
    logic [15:0] err_out, phase_out;

    int n_cmp = 0, n_bad = 0;
    int exp_q[$];
    event chk_ev;

    // reference model state
    longint m_ph = 0, m_int = 0;
    int m_y = 0, m_cnt = 0;
    bit m_lock = 0;

    gsync_pll u0 (.clk(clk), .rst(rst), .smp_en(smp_en), .smp_in(smp_in),
        .kp(kp), .ki(ki), .lock_thr(lock_thr), .sync_out(sync_out),
        .locked(locked), .err_out(err_out), .phase_out(phase_out));

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string req, longint got, longint exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_int = 0; m_y = 0; m_cnt = 0; m_lock = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        model_reset();
        // R1: cleared state at the ports
        chk("R1 phase", phase_out, 0);
        chk("R1 err", err_out, 0);
        chk("R1 locked", locked, 0);
        chk("R1 sync", sync_out, 1);
    endtask

    // driver: predicts the filter value and pushes it
    task automatic send(int x);
        int p;
        p = (m_ph < 32768) ? x : -x;
        m_y = m_y + ((p - m_y) >>> 3);
        exp_q.push_back(m_y);
        smp_in = 16'(x);
        smp_en = 1;
        @(negedge clk); smp_en = 0;
        repeat (17) @(negedge clk);
        -> chk_ev;
        @(negedge clk);
    endtask

    // monitor: pops expectations and compares with the outputs
    initial begin
        forever begin
            int y, ea, d, e, mag;
            longint t, uf, fw, old;
            real a;
            string tag;
            @(chk_ev);
            y = exp_q.pop_front();
            a = $atan2(real'(y), 4096.0) * 32768.0 / PI_R;
            ea = $rtoi(a + ((a >= 0.0) ? 0.5 : -0.5));
            d = int'(16'(err_out - 16'(ea)));
            d = (d >= 32768) ? d - 65536 : d;
            n_cmp++;
            if (d > 24 || d < -24) begin
                n_bad++;
                $display("FAIL R5 err got=%0d expected=%0d", $signed(err_out), ea);
            end
            e = int'($signed(err_out));
            t = m_int + longint'(ki) * e;
            if (t > IMAX) t = IMAX;
            if (t < -IMAX) t = -IMAX;
            m_int = t;
            uf = longint'(kp) * e + m_int;
            fw = 492 + (uf >>> 8);
            old = m_ph;
            m_ph = (m_ph + fw) & 64'hFFFF;
            if (ki != 0) tag = "R7 phase";
            else if (kp != 0) tag = "R6 phase";
            else if (m_ph < old) tag = "R3 phase wrap";
            else tag = "R2 phase";
            chk(tag, phase_out, m_ph);
            chk("R4 sync", sync_out, (m_ph < 32768) ? 1 : 0);
            mag = (e < 0) ? -e : e;
            if (mag < int'(lock_thr)) m_cnt = (m_cnt < 256) ? m_cnt + 1 : 256;
            else m_cnt = 0;
            m_lock = (m_cnt == 256);
            chk("R8 locked", locked, m_lock);
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog got=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] hp, he;
        do_reset();
        // free run across several wraps, sine input
        for (int n = 0; n < 150; n++)
            send($rtoi(16000.0 * $sin(2.0 * PI_R * 60.0 * n / 8000.0 + 0.7)));
        // constant negative input
        for (int n = 0; n < 20; n++) send(-20000);
        // R6 proportional only
        kp = 40;
        for (int n = 0; n < 60; n++)
            send($rtoi(20000.0 * $sin(2.0 * PI_R * 60.0 * n / 8000.0)));
        // R7 integral path
        kp = 10; ki = 3;
        for (int n = 0; n < 60; n++)
            send($rtoi(20000.0 * $sin(2.0 * PI_R * 60.0 * n / 8000.0 + PI_R)));
        // R7 saturation with large gain
        kp = 0; ki = 255;
        for (int n = 0; n < 30; n++) send(30000);
        // R9: no strobe, nothing moves
        hp = phase_out; he = err_out;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            chk("R9 phase hold", phase_out, hp);
            chk("R9 err hold", err_out, he);
        end
        // R1 mid-run reset, then R8 lock run
        kp = 0; ki = 0;
        do_reset();
        lock_thr = 16'hFFFF;
        for (int n = 0; n < 258; n++)
            send($rtoi(12000.0 * $sin(2.0 * PI_R * 60.0 * n / 8000.0)));
        chk("R8 lock set", locked, 1);
        lock_thr = 0;
        send(5000);
        chk("R8 lock clear", locked, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule